// File: doc/BRIEF.md
# Paired-Coefficient Forward NTT Engine

This block computes an in-place forward number-theoretic transform of a length-N polynomial over the prime field of modulus Q. The coefficients live in a single-port RAM in which every word carries two coefficients. The engine works on four coefficients at a time. It fetches two words, runs two butterflies on them and stores the two words back to the same addresses. Before the final stage the lanes are exchanged on the way out, so each word then holds the operand pair that the following stage needs. Each stage therefore touches every word once for reading and once for writing, which is half the traffic of a schedule that fetches one coefficient pair per butterfly.

A host fills the RAM through a word-wide port while the engine is idle, pulses `start`, waits for the one-cycle `done` pulse and then reads the result back through the same port. The twiddle factors are powers of a primitive N-th root of unity. They are held in a small ROM whose contents are computed when the design is elaborated.

Top module: `ntt_pair_engine`

## Requirements
- R1: After a cycle of synchronous active-low reset, `done` is low and the engine is idle, so host accesses act on the RAM at once.
- R2: While idle, a host write stores `host_wdata` at word `host_addr`, and `host_rdata` shows the word at `host_addr` one clock edge after the address is presented. A word's lane 0 sits in bits [QW-1:0] and lane 1 in bits [2*QW-1:QW], with QW = clog2(Q).
- R3: Let brev be the (log2(N)-1)-bit reversal. If word w is loaded with lane 0 = a[brev(w)] and lane 1 = a[brev(w)+N/2], then after the transform word w holds lane 0 = X[w] and lane 1 = X[w+N/2]. Here X[k] = sum over j of a[j]*W^(j*k) mod Q, and W is the smallest integer above 1 with W^(N/2) = Q-1 mod Q.
- R4: Every four-coefficient group takes exactly six cycles: two reads, two butterfly cycles and two writes. The RAM writes of the engine therefore always come as two consecutive cycles followed by a gap, and `done` is first seen high log2(N)*(N/4)*6 edges after the edge that accepts `start`.
- R5: A `start` pulse that arrives while a transform is running has no effect. The run ends at the same cycle and gives the same result.
- R6: Host writes made while a transform is running are ignored. The final RAM contents equal the R3 result.
- R7: `done` is high for exactly one cycle, and that cycle directly follows the final RAM write of the transform.
- R8: Corner inputs give the closed-form results. An all-zero input gives all zeros, a unit impulse at index 0 gives all ones, a unit impulse at index 1 gives X[k] = W^k, and all coefficients equal to Q-1 give X[0] = N*(Q-1) mod Q and zero elsewhere.
- R9: Every coefficient produced by a butterfly, and every coefficient in the result, is below Q, given inputs below Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a transform when sampled high while idle |
| done | output | 1 | One-cycle pulse after the last write of a transform |
| host_we | input | 1 | Host write strobe, honoured only while idle |
| host_addr | input | log2(N)-1 | Host word address |
| host_wdata | input | 2*QW | Host write word, lane 0 in the low half |
| host_rdata | output | 2*QW | Word read at the previous cycle's address |

## Verification
Directed inputs each have a closed-form answer. The zero vector and the impulse at 0 separate a correct datapath from one that drops or doubles contributions. The impulse at index 1 brings out every twiddle exponent in the output order on its own, so a wrong ROM index or a wrong lane exchange shows up at a known position. The all-(Q-1) vector drives the modular reduction at its largest operands. Random vectors reached through a fixed seed exercise all butterfly paths at once against a direct O(N^2) reference, and one random run is overlaid with stray `start` pulses and host writes to show that the engine shuts out host activity during a run.

// File: rtl/ntt_pkg.sv
// Package ntt_pkg
// Shared state encoding and elaboration-time arithmetic helpers for the
// paired-coefficient NTT engine. Assumes the modulus is an odd prime of at
// most 31 bits, so that products fit in a longint.
package ntt_pkg;

    // Scheduler phases: two reads, two butterfly cycles, two writes per group.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD0  = 3'd1,
        S_RD1  = 3'd2,
        S_BF0  = 3'd3,
        S_BF1  = 3'd4,
        S_WR0  = 3'd5,
        S_WR1  = 3'd6,
        S_DONE = 3'd7
    } sched_state_t;

    // Modular exponentiation by square-and-multiply.
    function automatic longint mod_pow(longint base, longint e, longint m);
        longint r = 1;
        longint b = base % m;
        longint x = e;
        while (x > 0) begin
            if ((x % 2) == 1) r = (r * b) % m;
            b = (b * b) % m;
            x = x / 2;
        end
        return r;
    endfunction

    // Smallest w > 1 whose N/2-th power is -1, that is, of order exactly n.
    function automatic longint find_root(longint n, longint q);
        longint w = 2;
        longint found = 0;
        while (found == 0 && w < q) begin
            if (mod_pow(w, n / 2, q) == q - 1) found = w;
            w = w + 1;
        end
        return found;
    endfunction

endpackage

// File: rtl/ntt_coef_ram.sv
// Module ntt_coef_ram
// Single-port coefficient store, one word per address, each word holding two
// coefficients. Read is synchronous with one cycle of latency, and a read in
// the cycle of a write returns the old word. No reset: contents are data.
module ntt_coef_ram #(
    parameter int AW = 7,
    parameter int WW = 26
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [WW-1:0] wdata,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    // Write on strobe, and register the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/ntt_twiddle_rom.sv
// Module ntt_twiddle_rom
// Holds W^k mod Q for k in [0, N/2), where W is the smallest element of order
// N. The table is computed at elaboration. The output is registered, so the
// factor appears one cycle after its index is presented.
module ntt_twiddle_rom #(
    parameter int N  = 256,
    parameter int Q  = 7681,
    parameter int QW = 13
) (
    input  logic                     clk,
    input  logic [$clog2(N)-2:0]     idx,
    output logic [QW-1:0]            tw
);
    localparam int     HALF = N / 2;
    localparam longint ROOT = ntt_pkg::find_root(N, Q);

    logic [QW-1:0] tab [HALF];

    // One constant entry per twiddle exponent.
    for (genvar k = 0; k < HALF; k++) begin : g_tab
        localparam logic [QW-1:0] VAL = QW'(ntt_pkg::mod_pow(ROOT, k, Q));
        assign tab[k] = VAL;
    end

    // Registered lookup.
    always_ff @(posedge clk) begin
        tw <= tab[idx];
    end
endmodule

// File: rtl/ntt_butterfly.sv
// Module ntt_butterfly
// Single-cycle Cooley-Tukey butterfly: t = b*w mod Q, sum = a+t, dif = a-t,
// all mod Q. The reduction uses Barrett's method with two correction steps.
// Assumes a, b and w are all below Q, and Q is odd with 2^(QW-1) < Q < 2^QW.
module ntt_butterfly #(
    parameter int Q  = 7681,
    parameter int QW = 13
) (
    input  logic [QW-1:0] a,
    input  logic [QW-1:0] b,
    input  logic [QW-1:0] w,
    output logic [QW-1:0] sum,
    output logic [QW-1:0] dif
);
    localparam int     PW = 2 * QW;              // product width
    localparam int     MW = QW + 1;              // Barrett constant width
    localparam int     RW = QW + 2;              // remainder before correction
    localparam longint MU_L = (longint'(1) << PW) / Q;
    localparam logic [MW-1:0]   MU  = MW'(MU_L);
    localparam logic [RW-1:0]   Q_R = RW'(Q);
    localparam logic [QW:0]     Q_S = (QW+1)'(Q);

    logic [PW-1:0]    prod;
    logic [PW+MW-1:0] scaled;
    logic [MW-1:0]    est;
    logic [RW-1:0]    rem0, rem1, rem2;
    logic [QW-1:0]    t;
    logic [QW:0]      s_raw;

    // Barrett reduction of b*w into [0, Q).
    always_comb begin
        prod   = PW'(b) * PW'(w);
        scaled = (PW+MW)'(prod) * (PW+MW)'(MU);
        est    = scaled[PW+MW-1:PW];
        rem0   = RW'(prod) - RW'(est) * Q_R;
        rem1   = (rem0 >= Q_R) ? rem0 - Q_R : rem0;
        rem2   = (rem1 >= Q_R) ? rem1 - Q_R : rem1;
        t      = QW'(rem2);
    end

    // Modular add and subtract of the scaled operand.
    always_comb begin
        s_raw = {1'b0, a} + {1'b0, t};
        sum   = (s_raw >= Q_S) ? QW'(s_raw - Q_S) : QW'(s_raw);
        dif   = (a >= t) ? (a - t) : QW'({1'b0, a} + Q_S - {1'b0, t});
    end
endmodule

// File: rtl/ntt_sched.sv
// Module ntt_sched
// Sequences the log2(N) stages of the transform. Each group reads two words,
// runs one butterfly per word, and writes both words back to their own
// addresses. Before the final stage the lanes are exchanged so that the next
// stage's operand pairs share a word. In the final stage the words are
// written back unchanged, which leaves X[w] and X[w+N/2] together in word w.
// Word layout before stage s (0-based): lane = index bit s, address bits
// [s-1:0] = index bits [s-1:0], higher address bits = index bits above s.
module ntt_sched #(
    parameter int LOG_N = 8,
    parameter int QW    = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                done,
    output logic                running,
    output logic [LOG_N-2:0]    ram_addr,
    output logic                ram_we,
    output logic [2*QW-1:0]     ram_wdata,
    input  logic [2*QW-1:0]     ram_rdata,
    output logic [LOG_N-2:0]    tw_idx,
    output logic [QW-1:0]       bf_a,
    output logic [QW-1:0]       bf_b,
    output logic                bf_fire,
    input  logic [QW-1:0]       bf_sum,
    input  logic [QW-1:0]       bf_dif
);
    import ntt_pkg::*;

    localparam int AW = LOG_N - 1;           // word address width
    localparam int GW = LOG_N - 2;           // group counter width
    localparam int SW = $clog2(LOG_N);       // stage counter width
    localparam int WW = 2 * QW;

    sched_state_t    state;
    logic [SW-1:0]   stage;
    logic [GW-1:0]   grp;
    logic            last_stage, last_grp;
    logic [SW-1:0]   pbit, tsh;
    logic [AW-1:0]   grp_x, low_mask, tmask, addr0, addr1;
    logic [WW-1:0]   w0, w1;
    logic [QW-1:0]   r0u, r0v, r1u, r1v;

    // Twiddle exponent of the butterfly that starts at word a in this stage.
    function automatic logic [AW-1:0] tw_exp(logic [AW-1:0] a,
                                             logic [AW-1:0] m,
                                             logic [SW-1:0] sh);
        return (a & m) << sh;
    endfunction

    // Stage and group decode into the two word addresses of the group.
    always_comb begin
        last_stage = (stage == SW'(LOG_N - 1));
        last_grp   = (grp == '1);
        pbit       = last_stage ? '0 : stage;
        grp_x      = AW'(grp);
        low_mask   = (AW'(1) << pbit) - AW'(1);
        addr0      = ((grp_x & ~low_mask) << 1) | (grp_x & low_mask);
        addr1      = addr0 | (AW'(1) << pbit);
        // In the final stage the shift wraps to zero, so the mask covers all bits.
        tmask      = (AW'(1) << stage) - AW'(1);
        tsh        = SW'(AW) - stage;
    end

    // Twiddle request: word 0 during RD1, word 1 during BF0 (ROM is registered).
    always_comb begin
        tw_idx = (state == S_RD1) ? tw_exp(addr0, tmask, tsh)
                                  : tw_exp(addr1, tmask, tsh);
    end

    // Butterfly operand select: first word in BF0, second word in BF1.
    always_comb begin
        bf_fire = (state == S_BF0) || (state == S_BF1);
        bf_a    = (state == S_BF1) ? w1[QW-1:0]  : w0[QW-1:0];
        bf_b    = (state == S_BF1) ? w1[WW-1:QW] : w0[WW-1:QW];
    end

    // RAM port drive: address by phase, write data exchanged except in final stage.
    always_comb begin
        ram_addr  = (state == S_RD1 || state == S_WR1) ? addr1 : addr0;
        ram_we    = (state == S_WR0) || (state == S_WR1);
        if (state == S_WR0) ram_wdata = last_stage ? {r0v, r0u} : {r1u, r0u};
        else                ram_wdata = last_stage ? {r1v, r1u} : {r1v, r0v};
        done      = (state == S_DONE);
        running   = (state != S_IDLE);
    end

    // Capture fetched words and butterfly results; datapath registers need no reset.
    always_ff @(posedge clk) begin
        case (state)
            S_RD1: w0 <= ram_rdata;
            S_BF0: begin
                w1  <= ram_rdata;
                r0u <= bf_sum;
                r0v <= bf_dif;
            end
            S_BF1: begin
                r1u <= bf_sum;
                r1v <= bf_dif;
            end
            default: ;
        endcase
    end

    // Phase, group and stage sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            stage <= '0;
            grp   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state <= S_RD0;
                    stage <= '0;
                    grp   <= '0;
                end
                S_RD0:  state <= S_RD1;
                S_RD1:  state <= S_BF0;
                S_BF0:  state <= S_BF1;
                S_BF1:  state <= S_WR0;
                S_WR0:  state <= S_WR1;
                S_WR1: begin
                    if (!last_grp) begin
                        grp   <= grp + GW'(1);
                        state <= S_RD0;
                    end else if (!last_stage) begin
                        grp   <= '0;
                        stage <= stage + SW'(1);
                        state <= S_RD0;
                    end else begin
                        state <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ntt_pair_engine.sv
// Module ntt_pair_engine
// Top of the paired-coefficient forward NTT. Owns the coefficient RAM and
// hands its single port to the host while idle and to the scheduler while a
// transform runs (including the done cycle). Assumes N is a power of two of at
// least 8, Q is a prime with Q = 1 mod N, and the loaded coefficients are below Q.
module ntt_pair_engine #(
    parameter int  N     = 256,
    parameter int  Q     = 7681,
    localparam int LOG_N = $clog2(N),
    localparam int QW    = $clog2(Q),
    localparam int WW    = 2 * QW,
    localparam int AW    = LOG_N - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [WW-1:0] host_wdata,
    output logic [WW-1:0] host_rdata
);
    logic          running, eng_we, bf_fire, ram_we;
    logic [AW-1:0] eng_addr, ram_addr, tw_idx;
    logic [WW-1:0] eng_wdata, ram_wdata, ram_rdata;
    logic [QW-1:0] tw, bf_a, bf_b, bf_sum, bf_dif;

    // Port ownership: host when idle, engine otherwise.
    always_comb begin
        ram_addr   = running ? eng_addr  : host_addr;
        ram_we     = running ? eng_we    : host_we;
        ram_wdata  = running ? eng_wdata : host_wdata;
        host_rdata = ram_rdata;
    end

    ntt_coef_ram #(.AW(AW), .WW(WW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    ntt_twiddle_rom #(.N(N), .Q(Q), .QW(QW)) u_rom (
        .clk (clk),
        .idx (tw_idx),
        .tw  (tw)
    );

    ntt_butterfly #(.Q(Q), .QW(QW)) u_bf (
        .a   (bf_a),
        .b   (bf_b),
        .w   (tw),
        .sum (bf_sum),
        .dif (bf_dif)
    );

    ntt_sched #(.LOG_N(LOG_N), .QW(QW)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .done      (done),
        .running   (running),
        .ram_addr  (eng_addr),
        .ram_we    (eng_we),
        .ram_wdata (eng_wdata),
        .ram_rdata (ram_rdata),
        .tw_idx    (tw_idx),
        .bf_a      (bf_a),
        .bf_b      (bf_b),
        .bf_fire   (bf_fire),
        .bf_sum    (bf_sum),
        .bf_dif    (bf_dif)
    );
endmodule

// File: rtl/ntt_pair_engine_chk.sv
// Module ntt_pair_engine_chk
// Protocol and range checks for ntt_pair_engine, attached with bind.
// Observes the start/done handshake, the engine's RAM write strobe and the
// butterfly outputs.
module ntt_pair_engine_chk #(
    parameter int QW = 13,
    parameter int Q  = 7681
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          running,
    input logic          eng_we,
    input logic          bf_fire,
    input logic [QW-1:0] bf_sum,
    input logic [QW-1:0] bf_dif
);
    localparam logic [QW-1:0] Q_C = QW'(Q);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R7
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(eng_we));                                    // R7
    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !$past(eng_we)) |=> eng_we);                            // R4
    AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && $past(eng_we)) |=> !eng_we);                            // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !done) |=> running);                          // R5
    AST_COEF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bf_fire |-> (bf_sum < Q_C && bf_dif < Q_C));                       // R9
endmodule

bind ntt_pair_engine ntt_pair_engine_chk #(.QW(QW), .Q(Q)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .running (running),
    .eng_we  (eng_we),
    .bf_fire (bf_fire),
    .bf_sum  (bf_sum),
    .bf_dif  (bf_dif)
);

// File: tb/test_ntt_pair_engine.sv
`timescale 1ns/1ps
module test_ntt_pair_engine;
    localparam int N      = 256;
    localparam int Q      = 7681;
    localparam int LOG_N  = 8;
    localparam int QW     = 13;
    localparam int WW     = 26;
    localparam int AW     = 7;
    localparam int RUN_CY = LOG_N * (N / 4) * 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [WW-1:0] host_wdata = '0;
    logic [WW-1:0] host_rdata;

    int checks = 0;
    int fails  = 0;
    longint root;
    longint pw [N];
    int vec_a [N];
    int exp_x [N];

    always #10 clk = ~clk;   // 50 MHz

    ntt_pair_engine i_ntt_pair_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic longint tb_pow(longint b, longint e);
        longint r = 1;
        longint x = b % Q;
        for (longint k = e; k > 0; k = k / 2) begin
            if ((k % 2) == 1) r = (r * x) % Q;
            x = (x * x) % Q;
        end
        return r;
    endfunction

    function automatic int brev(int w);
        int r = 0;
        for (int i = 0; i < AW; i++) if (((w >> i) & 1) == 1) r = r | (1 << (AW - 1 - i));
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Direct O(N^2) transform of vec_a into exp_x.
    task automatic ref_ntt();
        for (int k = 0; k < N; k++) begin
            longint acc = 0;
            for (int j = 0; j < N; j++) acc = (acc + longint'(vec_a[j]) * pw[(j * k) % N]) % Q;
            exp_x[k] = int'(acc);
        end
    endtask

    task automatic load_vec();
        for (int w = 0; w < N / 2; w++) begin
            @(negedge clk);
            host_we    = 1'b1;
            host_addr  = AW'(w);
            host_wdata = {QW'(vec_a[brev(w) + N / 2]), QW'(vec_a[brev(w)])};
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Start a run, optionally disturbing it, and check its length and done width.
    task automatic run_ntt(bit disturb);
        int cnt = 0;
        bit seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!seen && cnt < RUN_CY + 20) begin
            if (disturb) begin
                host_we    = ($urandom % 2) == 1;
                host_addr  = AW'($urandom);
                host_wdata = WW'($urandom);
                start      = ($urandom % 5) == 0;
            end
            @(negedge clk);
            cnt++;
            if (done) seen = 1'b1;
        end
        host_we = 1'b0;
        start   = 1'b0;
        check(seen && cnt == RUN_CY, disturb ? "R5" : "R4", "edges from start to done", cnt, RUN_CY);
        @(negedge clk);
        check(done == 1'b0, "R7", "done width", done, 0);
    endtask

    // Read the whole RAM and compare with exp_x; one check for value, one for range.
    task automatic read_check(string req);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        int over = 0;
        for (int w = 0; w < N / 2; w++) begin
            int lo, hi;
            @(negedge clk); host_addr = AW'(w);
            @(negedge clk);
            lo = int'(host_rdata[QW-1:0]);
            hi = int'(host_rdata[WW-1:QW]);
            if (lo >= Q || hi >= Q) over++;
            if (lo != exp_x[w]) begin
                if (bad == 0) begin first_act = lo; first_exp = exp_x[w]; end
                bad++;
            end
            if (hi != exp_x[w + N / 2]) begin
                if (bad == 0) begin first_act = hi; first_exp = exp_x[w + N / 2]; end
                bad++;
            end
        end
        check(bad == 0, req, "transform coefficient", first_act, first_exp);
        check(over == 0, "R9", "coefficients at or above Q", over, 0);
    endtask

    task automatic full_case(string req, bit disturb);
        ref_ntt();
        load_vec();
        run_ntt(disturb);
        read_check(req);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        root = 2;
        while (tb_pow(root, N / 2) != Q - 1) root++;
        for (int e = 0; e < N; e++) pw[e] = tb_pow(root, e);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        // R2: host access while idle, one-edge read latency.
        @(negedge clk); host_we = 1'b1; host_addr = 7'd5; host_wdata = {13'd1234, 13'd7680};
        @(negedge clk); host_addr = 7'd127; host_wdata = {13'd7680, 13'd1};
        @(negedge clk); host_we = 1'b0; host_addr = 7'd5;
        @(negedge clk);
        check(host_rdata == {13'd1234, 13'd7680}, "R2", "word 5 readback", host_rdata, {13'd1234, 13'd7680});
        host_addr = 7'd127;
        @(negedge clk);
        check(host_rdata == {13'd7680, 13'd1}, "R2", "word 127 readback", host_rdata, {13'd7680, 13'd1});
        check(host_rdata[QW-1:0] == 13'd1, "R2", "lane 0 field", host_rdata[QW-1:0], 1);

        // R8 corner inputs.
        for (int j = 0; j < N; j++) vec_a[j] = 0;
        full_case("R8 zero input", 1'b0);
        check(exp_x[3] == 0, "R8", "zero reference", exp_x[3], 0);

        vec_a[0] = 1;
        full_case("R8 impulse at 0", 1'b0);
        check(exp_x[N - 1] == 1, "R8", "impulse 0 reference", exp_x[N - 1], 1);

        vec_a[0] = 0; vec_a[1] = 1;
        full_case("R8 impulse at 1", 1'b0);
        check(longint'(exp_x[5]) == pw[5], "R8", "impulse 1 reference", exp_x[5], pw[5]);

        for (int j = 0; j < N; j++) vec_a[j] = Q - 1;
        full_case("R8 all Q-1", 1'b0);
        check(exp_x[0] == (N * (Q - 1)) % Q && exp_x[1] == 0, "R8", "all Q-1 reference",
              exp_x[0], (N * (Q - 1)) % Q);

        // R3 random vectors.
        for (int v = 0; v < 3; v++) begin
            for (int j = 0; j < N; j++) vec_a[j] = int'($urandom % Q);
            full_case("R3 random vector", 1'b0);
        end

        // R5/R6: random vector with stray start pulses and host writes during the run.
        for (int j = 0; j < N; j++) vec_a[j] = int'($urandom % Q);
        full_case("R6 host writes during run", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule